// File: doc/BRIEF.md
# Predictive Synchronous Rectifier Gate Timer

This block produces the two gate-enable signals for the secondary-side rectifier switches of a forward converter. Its only timing reference is the square-wave switching clock recovered from the isolation transformer. It samples that clock on a much faster internal clock. The internal clock period is the timing resolution.

Each output channel measures one interval during a switching cycle. The forward channel measures the on-time, from rising edge to falling edge. The freewheel channel measures the full period, from rising edge to rising edge. In the next cycle, each channel uses its stored value to drop its gate a programmable number of internal ticks before the predicted switching-clock edge. The turn-off therefore happens before the real edge arrives, which prevents shoot-through. Each channel uses two counters that swap roles at every rising edge: one re-measures the current cycle while the other counts down the prediction taken from the previous cycle.

All pins are plain level signals. Nothing flows in a stream, so there is no handshake or back-pressure. The anticipation settings are quasi-static and are captured once per cycle.

Top module: `sr_gate_timer`

## Requirements
- R1: Both gates are low during reset. They stay low until a complete measurement exists, so no gate goes high before the second detected rising edge of `sw_clk`.
- R2: `sw_clk` passes through a two-flop synchronizer. A level first sampled at internal edge e is recognized as a rise or fall event in the cycle that follows edge e+1.
- R3: `gate_fwd` goes high in the cycle after a rise event. It stays high for n1−x1 cycles, where:
  - n1 is the number of cycles from the previous rise event to the fall event that followed it.
  - x1 is `antic_fwd`.

  `gate_fwd` is low in any fall-event cycle and at all times after a fall event.
- R4: `gate_frw` goes high in the cycle after a fall event. It stays high while the cycle count since the latest rise event is at most n2−x2, where:
  - n2 is the number of cycles between the two latest rise events.
  - x2 is `antic_frw`.

  `gate_frw` is low in any rise-event cycle.
- R5: `gate_fwd` and `gate_frw` are never high together.
  - Any switch from `gate_frw` to `gate_fwd` leaves at least the rise-event cycle with both gates low.
  - Any switch from `gate_fwd` to `gate_frw` leaves at least the fall-event cycle with both gates low.
- R6: If a measured interval is no larger than its anticipation count (n1 ≤ x1, or n2 ≤ x2), that gate stays low for the whole next cycle.
- R7: A change in period or on-time affects the gates only from the following switching cycle onward.
- R8: A measurement counter saturates at its all-ones value (2^ON_W−1 for on-time, 2^PER_W−1 for period). A saturated measurement is invalid and keeps that gate low during the next cycle.
- R9: The anticipation inputs are captured in the rise-event cycle. A change at any other time has no effect until the next rise event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clk | input | 1 | Switching clock recovered from the transformer (asynchronous) |
| antic_fwd | input | ANT_W | Turn-off advance of `gate_fwd`, in internal ticks |
| antic_frw | input | ANT_W | Turn-off advance of `gate_frw`, in internal ticks |
| gate_fwd | output | 1 | Forward rectifier gate enable |
| gate_frw | output | 1 | Freewheel rectifier gate enable |

## Verification
A steady period and duty cycle show that both gates open one tick after their enabling edge and close exactly the programmed number of ticks early. Anticipation values set equal to, and one below, the measured interval separate the "stays off" boundary from a one-tick pulse. Step changes in on-time and period, and a long high phase and a long low phase that drive each counter into saturation, show the one-cycle lag and the recovery after an invalid measurement. Anticipation changes placed mid-cycle, together with random periods, duties and settings, confirm that the settings are captured only at the rising edge and that the two gates never overlap.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // conduction phase of the secondary side, as seen from the switching clock
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FWD  = 2'd1,
    PH_FRW  = 2'd2
  } phase_t;
endpackage

// File: rtl/srt_edge_sync.sv
module srt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_in,
  output logic rise_p,
  output logic fall_p
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], sw_in};
  end

  assign rise_p =  pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_p = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/srt_predictor.sv
// Two counters alternate roles at every start pulse: one measures the
// current interval upward, the other counts down the previous measurement
// minus the anticipation. win is high while that countdown is running.
module srt_predictor #(
  parameter int CW     = 12,
  parameter int XW     = 6,
  parameter bit FREEZE = 1'b0   // 1: the interval ends at stop_p, 0: at the next start_p
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [XW-1:0] antic,
  output logic          win
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          role;      // index of the counter currently measuring
  logic          armed;     // a start pulse has been seen since reset
  logic          held;      // the measuring counter has been frozen this cycle
  logic          pred_ok;   // the running countdown came from a valid measurement
  logic [CW-1:0] up_val;
  logic [CW-1:0] dn_val;
  logic [CW-1:0] x_ext;
  logic          freeze_now;
  logic          meas_ok;
  logic          load_ok;

  assign x_ext      = CW'(antic);
  assign freeze_now = FREEZE ? stop_p : 1'b0;
  assign meas_ok    = armed & (held | ~FREEZE) & (up_val != CMAX);
  assign load_ok    = meas_ok & (up_val > x_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role    <= 1'b0;
      armed   <= 1'b0;
      held    <= 1'b0;
      pred_ok <= 1'b0;
    end else if (start_p) begin
      role    <= ~role;
      armed   <= 1'b1;
      held    <= 1'b0;
      pred_ok <= load_ok;
    end else if (armed && freeze_now) begin
      held    <= 1'b1;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    logic [CW-1:0] val;
    logic          is_up;
    assign is_up = (role == 1'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val <= '0;
      end else if (start_p) begin
        // the measuring counter turns into the countdown and vice versa
        val <= is_up ? (load_ok ? val - x_ext : '0) : CW'(1);
      end else if (is_up) begin
        if (armed && !held && !freeze_now && val != CMAX) val <= val + 1'b1;
      end else if (val != '0) begin
        val <= val - 1'b1;
      end
    end
  end

  assign up_val = role ? g_ctr[1].val : g_ctr[0].val;
  assign dn_val = role ? g_ctr[0].val : g_ctr[1].val;
  assign win    = pred_ok & (dn_val != '0);
endmodule

// File: rtl/srt_gate_mux.sv
module srt_gate_mux
  import srt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_p,
  input  logic fall_p,
  input  logic win_fwd,
  input  logic win_frw,
  output logic gate_fwd,
  output logic gate_frw
);
  phase_t phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= PH_IDLE;
    else if (rise_p) phase <= PH_FWD;
    else if (fall_p) phase <= PH_FRW;
  end

  // the event cycle itself is the dead tick for the gate being released
  assign gate_fwd = (phase == PH_FWD) & win_fwd & ~fall_p;
  assign gate_frw = (phase == PH_FRW) & win_frw & ~rise_p;
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer #(
  parameter int PER_W       = 12,
  parameter int ON_W        = 11,
  parameter int ANT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clk,
  input  logic [ANT_W-1:0] antic_fwd,
  input  logic [ANT_W-1:0] antic_frw,
  output logic             gate_fwd,
  output logic             gate_frw
);
  logic rise_p;
  logic fall_p;
  logic win_fwd;
  logic win_frw;

  srt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_in  (sw_clk),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  // on-time: rise to fall
  srt_predictor #(.CW(ON_W), .XW(ANT_W), .FREEZE(1'b1)) u_pred_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_p (rise_p),
    .stop_p  (fall_p),
    .antic   (antic_fwd),
    .win     (win_fwd)
  );

  // period: rise to rise
  srt_predictor #(.CW(PER_W), .XW(ANT_W), .FREEZE(1'b0)) u_pred_frw (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_p (rise_p),
    .stop_p  (1'b0),
    .antic   (antic_frw),
    .win     (win_frw)
  );

  srt_gate_mux u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .win_fwd  (win_fwd),
    .win_frw  (win_frw),
    .gate_fwd (gate_fwd),
    .gate_frw (gate_frw)
  );
endmodule

// File: rtl/srt_gate_checker.sv
module srt_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic rise_p,
  input logic fall_p,
  input logic gate_fwd,
  input logic gate_frw
);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_fwd && gate_frw));

  p_fwd_dead_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_p |-> !gate_fwd);

  p_frw_dead_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> !gate_frw);

  p_fwd_opens_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fwd) |-> $past(rise_p));

  p_frw_opens_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_frw) |-> $past(fall_p));
endmodule

bind sr_gate_timer srt_gate_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise_p   (rise_p),
  .fall_p   (fall_p),
  .gate_fwd (gate_fwd),
  .gate_frw (gate_frw)
);

// File: tb/tb_sr_gate_timer.sv
module tb_sr_gate_timer;
  localparam int PER_W = 12;
  localparam int ON_W  = 11;
  localparam int ANT_W = 6;
  localparam int MAXP  = (1 << PER_W) - 1;
  localparam int MAXO  = (1 << ON_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sw_clk = 1'b0;
  logic [ANT_W-1:0] antic_fwd = '0;
  logic [ANT_W-1:0] antic_frw = '0;
  logic             gate_fwd;
  logic             gate_frw;

  always #2 clk = ~clk;   // 250 MHz

  sr_gate_timer #(.PER_W(PER_W), .ON_W(ON_W), .ANT_W(ANT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sw_clk(sw_clk),
    .antic_fwd(antic_fwd), .antic_frw(antic_frw),
    .gate_fwd(gate_fwd), .gate_frw(gate_frw)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // ---------------- reference model (from the requirements) ----------------
  bit h1, h2;              // sw_clk sampled one and two edges ago
  int cyc;
  int r_last, f_last, rises, evt;   // evt: 0 none, 1 last event rise, 2 fall
  int n1, n2, x1u, x2u;
  bit v1, v2;
  bit exp_fwd, exp_frw;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; cyc = 0; r_last = 0; f_last = 0; rises = 0; evt = 0;
      n1 = 0; n2 = 0; x1u = 0; x2u = 0; v1 = 0; v2 = 0;
      exp_fwd = 0; exp_frw = 0;
    end else begin
      bit re, fe;
      re = h1 && !h2;   // R2: event one cycle after the second sample edge
      fe = !h1 && h2;
      exp_fwd = (evt == 1) && !fe && v1 && (n1 > x1u) && (cyc - r_last <= n1 - x1u);
      exp_frw = (evt == 2) && !re && v2 && (n2 > x2u) && (cyc - r_last <= n2 - x2u);
      if (re) begin
        v2 = (rises >= 1) && (cyc - r_last < MAXP);
        n2 = cyc - r_last;
        v1 = (rises >= 1) && (evt == 2) && (f_last - r_last < MAXO);
        n1 = f_last - r_last;
        x1u = int'(antic_fwd);   // R9: captured at the rise event
        x2u = int'(antic_frw);
        r_last = cyc; rises++; evt = 1;
      end
      if (fe) begin
        f_last = cyc; evt = 2;
      end
      h2 = h1; h1 = sw_clk;
      cyc++;
    end
  end

  task automatic chk(input string what, input logic got, input logic want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, what, got, want, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("gate_fwd", gate_fwd, exp_fwd);
      chk("gate_frw", gate_frw, exp_frw);
      n_chk++;
      if (gate_fwd && gate_frw) begin   // R5
        n_bad++;
        $display("FAIL R5 overlap: got fwd=%0b frw=%0b expected not both", gate_fwd, gate_frw);
      end
    end
  end

  // one switching cycle starting at a negedge
  task automatic sw_cycle(input int on_t, input int off_t);
    sw_clk = 1'b1;
    repeat (on_t) @(negedge clk);
    sw_clk = 1'b0;
    repeat (off_t) @(negedge clk);
  endtask

  task automatic set_antic(input int a1, input int a2);
    antic_fwd = ANT_W'(a1);
    antic_frw = ANT_W'(a2);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    tag = "R1";
    chk("gate_fwd in reset", gate_fwd, 1'b0);
    chk("gate_frw in reset", gate_frw, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("gate_fwd after reset", gate_fwd, 1'b0);
    chk("gate_frw after reset", gate_frw, 1'b0);

    // R1 / R2 / R3 / R4: steady operation from the first measured cycle
    set_antic(3, 4);
    tag = "R1";
    sw_cycle(20, 30);
    tag = "R3/R4";
    repeat (4) sw_cycle(20, 30);

    // R6: anticipation equal to and one below the measured interval
    tag = "R6";
    set_antic(20, 50); sw_cycle(20, 30); sw_cycle(20, 30);
    set_antic(19, 49); sw_cycle(20, 30); sw_cycle(20, 30);
    set_antic(63, 63); sw_cycle(20, 30); sw_cycle(20, 30);
    set_antic(0, 0);   sw_cycle(20, 30); sw_cycle(20, 30);

    // R7: step changes take effect one cycle later
    tag = "R7";
    set_antic(2, 2);
    sw_cycle(40, 20); sw_cycle(10, 50); sw_cycle(10, 10); sw_cycle(45, 45); sw_cycle(5, 60);

    // R9: anticipation changed in the middle of a cycle
    tag = "R9";
    sw_clk = 1'b1; repeat (10) @(negedge clk);
    antic_fwd = ANT_W'(9);
    repeat (20) @(negedge clk);
    sw_clk = 1'b0; repeat (10) @(negedge clk);
    antic_frw = ANT_W'(15);
    repeat (30) @(negedge clk);
    sw_cycle(30, 40); sw_cycle(30, 40);

    // R8: on-time saturation, then period saturation, then recovery
    tag = "R8";
    set_antic(1, 1);
    sw_cycle(MAXO + 60, 30); sw_cycle(30, 30);
    sw_cycle(30, MAXP + 50); sw_cycle(30, 30); sw_cycle(30, 30);

    // random periods, duties and settings
    tag = "R3/R4/R7";
    for (int k = 0; k < 40; k++) begin
      set_antic(int'($urandom_range(0, 63)), int'($urandom_range(0, 63)));
      sw_cycle(int'($urandom_range(2, 90)), int'($urandom_range(2, 90)));
    end
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL %s watchdog: got still running, expected finished", tag);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule